// File: doc/BRIEF.md
# Supply voltage monitor sequencer

This block is the digital controller that sits beside an external low-voltage comparator. It decides when the comparator is powered. It ignores the comparator while the comparator settles after power-on. It turns the comparator's samples into a live detection status, and it turns runs of low-voltage samples into either an interrupt or a system reset request. The comparator and its voltage reference are outside the block. The comparator is seen as a single input, `cmp_low`, which is 1 when the supply is below the threshold. The threshold code is passed straight through to the comparator.

Software-visible settings arrive as plain configuration inputs:

- enable
- mode
- threshold code
- consecutive-count select
- action select
- interrupt enable

The write-1-to-clear of the interrupt flag arrives as a one-cycle strobe. In continuous mode the comparator stays powered and the status tracks it on every cycle. In intermittent mode the comparator is powered once per interval for one sample and then switched off. An event needs a programmable number of consecutive low samples.

Top module: `supply_monitor`

## Requirements
- R1: `cfg_mode` 0 keeps the comparator powered while enabled. In intermittent mode, `cmp_power` rises once per interval, measured from one rise to the next: 256 cycles for mode 1, 1024 for mode 2 and 4096 for mode 3. Each time it stays high for 17 cycles (16 masking cycles and 1 sample cycle).
- R2: With `cfg_enable` low, `cmp_power`, `det_status` and the consecutive-low run count are all 0 from the next edge on. After `cfg_enable` is seen high from idle, `cmp_power` rises at the next edge.
- R3: During the first 16 powered cycles after each power-on, `cmp_low` has no effect on `det_status` or on any event.
- R4: In continuous mode, after the masking time `det_status` equals the `cmp_low` value of the previous cycle.
- R5: In intermittent mode, `det_status` takes the single sample taken in the 17th powered cycle and holds it until the next sample.
- R6: In intermittent mode, a low sample raises an event when the run of consecutive low samples reaches N. `cfg_count_sel` values 0, 1, 2 and 3 give N = 1, 2, 4 and 8. A sample that is not low sets the run to 0. Further low samples keep raising events.
- R7: In continuous mode an event is raised in every cycle in which `det_status` becomes or stays 1.
- R8: When `cfg_action_sel` is 4'hA, the first cycle of a run of event cycles produces a one-cycle `rst_req` pulse, one cycle after `det_status` updates, and `irq_flag` is unaffected. With any other value, events set `irq_flag` instead.
- R9: `irq_flag` is sticky. A `flag_clr` pulse clears it at the next edge, but a flag set in the same cycle wins.
- R10: `irq_req` equals `irq_flag` AND `cfg_irq_en`.
- R11: `cmp_level` always equals `cfg_level`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Detector clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | Monitor enable |
| cfg_mode | input | 2 | 0 continuous, 1..3 intermittent interval select |
| cfg_level | input | 5 | Detection threshold code for the comparator |
| cfg_count_sel | input | 2 | Consecutive-low count select (1, 2, 4, 8) |
| cfg_action_sel | input | 4 | 4'hA routes events to reset, otherwise to interrupt |
| cfg_irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Write-1-to-clear strobe for the interrupt flag |
| cmp_low | input | 1 | Comparator output, 1 = supply below threshold |
| cmp_power | output | 1 | Comparator power enable |
| cmp_level | output | 5 | Threshold code to the comparator |
| det_status | output | 1 | Live detection status |
| irq_flag | output | 1 | Sticky interrupt flag |
| irq_req | output | 1 | Interrupt request |
| rst_req | output | 1 | One-cycle reset request |

## Verification
A wrong sequencer state shows up at `cmp_power` within one cycle. A miscounted interval or masking window shifts the next rising edge, so the fault is visible by the following interval at the latest. A corrupted consecutive-low count stays hidden until the next low sample. At that point `irq_flag` or `rst_req` appears one interval too early or too late. The bench therefore holds the supply low across several intervals and breaks runs with a single good sample. A bad flag or routing decision is visible at `irq_flag`, `irq_req` or `rst_req` one edge after the status update.

// File: rtl/svm_pkg.sv
// Shared types and constants for the supply monitor.
// Assumes: all users compile this package first.
package svm_pkg;

    // Sequencer phase for the comparator power cycle.
    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_MASK,
        SEQ_LIVE,
        SEQ_TAKE,
        SEQ_WAIT
    } seq_state_t;

    // Action select value that turns detections into reset requests.
    localparam logic [3:0] RESET_KEY = 4'hA;

endpackage

// File: rtl/svm_seq.sv
// Comparator power sequencer.
// Powers the comparator, waits out the masking time and then marks valid
// sample cycles: every cycle in continuous mode, or one cycle per interval
// in intermittent mode, after which the comparator is switched off.
// Assumes: the intervals are larger than MASK_CYC + 1.
module svm_seq
    import svm_pkg::*;
#(
    parameter int MASK_CYC = 16,
    parameter int INTV1    = 256,
    parameter int INTV2    = 1024,
    parameter int INTV3    = 4096
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [1:0] mode,
    output logic       power,
    output logic       smp_valid
);

    localparam int MW = (MASK_CYC > 1) ? $clog2(MASK_CYC) : 1;
    localparam int IW = $clog2(INTV3);
    localparam logic [MW-1:0] MASK_LAST = MW'(MASK_CYC - 1);
    localparam logic [IW-1:0] WAIT1 = IW'(INTV1 - MASK_CYC - 2);
    localparam logic [IW-1:0] WAIT2 = IW'(INTV2 - MASK_CYC - 2);
    localparam logic [IW-1:0] WAIT3 = IW'(INTV3 - MASK_CYC - 2);

    seq_state_t      st;
    logic [MW-1:0]   mcnt;
    logic [IW-1:0]   icnt;
    logic [IW-1:0]   wait_last;
    logic            cont;

    assign cont = (mode == 2'd0);

    // Last off-cycle count of the selected interval.
    always_comb begin
        unique case (mode)
            2'd1:    wait_last = WAIT1;
            2'd2:    wait_last = WAIT2;
            default: wait_last = WAIT3;
        endcase
    end

    // Phase register with masking and off-time counters.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            st   <= SEQ_IDLE;
            mcnt <= '0;
            icnt <= '0;
        end else begin
            unique case (st)
                SEQ_IDLE: begin
                    st   <= SEQ_MASK;
                    mcnt <= '0;
                end
                SEQ_MASK: begin
                    if (mcnt == MASK_LAST) begin
                        st   <= cont ? SEQ_LIVE : SEQ_TAKE;
                        mcnt <= '0;
                    end else begin
                        mcnt <= mcnt + 1'b1;
                    end
                end
                SEQ_LIVE: begin
                    if (!cont) begin
                        st   <= SEQ_WAIT;
                        icnt <= '0;
                    end
                end
                SEQ_TAKE: begin
                    st   <= SEQ_WAIT;
                    icnt <= '0;
                end
                SEQ_WAIT: begin
                    if (cont || icnt >= wait_last) begin
                        st   <= SEQ_MASK;
                        mcnt <= '0;
                    end else begin
                        icnt <= icnt + 1'b1;
                    end
                end
                default: st <= SEQ_IDLE;
            endcase
        end
    end

    // Comparator power and sample strobe decoded from the phase.
    always_comb begin
        power     = (st == SEQ_MASK) || (st == SEQ_LIVE) || (st == SEQ_TAKE);
        smp_valid = (st == SEQ_LIVE) || (st == SEQ_TAKE);
    end

endmodule

// File: rtl/svm_detect.sv
// Detection status and consecutive-low debounce.
// Captures each valid sample into the status and counts consecutive low
// samples. It produces a one-cycle event per qualifying sample: every low
// sample in continuous mode, or a low sample that completes the selected
// run length in intermittent mode.
// Assumes: smp_valid only occurs after the masking time.
module svm_detect #(
    parameter int MAX_SEL = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       cont,
    input  logic       smp_valid,
    input  logic       cmp_low,
    input  logic [1:0] cnt_sel,
    output logic       status,
    output logic       evt
);

    localparam int RUN_MAX = 1 << MAX_SEL;
    localparam int RW      = $clog2(RUN_MAX + 1);
    localparam logic [RW-1:0] RUN_TOP = RW'(RUN_MAX);

    logic [RW-1:0] run;
    logic [RW-1:0] run_next;
    logic [RW-1:0] need;

    // Saturating run increment and run length required by the count select.
    always_comb begin
        run_next = (run == RUN_TOP) ? run : run + 1'b1;
        need     = RW'(1) << cnt_sel;
    end

    // Status capture, run counting and event strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            status <= 1'b0;
            run    <= '0;
            evt    <= 1'b0;
        end else if (smp_valid) begin
            status <= cmp_low;
            run    <= cmp_low ? run_next : '0;
            evt    <= cmp_low && (cont || run_next >= need);
        end else begin
            evt    <= 1'b0;
        end
    end

endmodule

// File: rtl/svm_route.sv
// Event routing to the interrupt flag or the reset request.
// With the reset key selected, the first cycle of a run of event cycles
// gives a one-cycle reset pulse; otherwise events set a sticky flag that a
// clear strobe resets, with set taking priority.
// Assumes: flag_clr is a single-cycle strobe from the register write path.
module svm_route
    import svm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       evt,
    input  logic [3:0] act_sel,
    input  logic       flag_clr,
    input  logic       irq_en,
    output logic       flag,
    output logic       irq,
    output logic       rst_pulse
);

    logic to_reset;
    logic evt_d;

    assign to_reset = (act_sel == RESET_KEY);

    // Flag, reset pulse and event history registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag      <= 1'b0;
            rst_pulse <= 1'b0;
            evt_d     <= 1'b0;
        end else begin
            evt_d     <= evt;
            rst_pulse <= evt && to_reset && !evt_d;
            if (evt && !to_reset) begin
                flag <= 1'b1;
            end else if (flag_clr) begin
                flag <= 1'b0;
            end
        end
    end

    // Interrupt request gated by its enable.
    assign irq = flag && irq_en;

endmodule

// File: rtl/supply_monitor.sv
// Supply voltage monitor sequencer, top level.
// Ties the power sequencer, the detector and the event router together and
// forwards the threshold code to the external comparator.
// Assumes: configuration inputs come from registers in the clk domain and
// cmp_low is already synchronised to clk.
module supply_monitor #(
    parameter int MASK_CYC = 16,
    parameter int INTV1    = 256,
    parameter int INTV2    = 1024,
    parameter int INTV3    = 4096,
    parameter int LVL_W    = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_enable,
    input  logic [1:0]       cfg_mode,
    input  logic [LVL_W-1:0] cfg_level,
    input  logic [1:0]       cfg_count_sel,
    input  logic [3:0]       cfg_action_sel,
    input  logic             cfg_irq_en,
    input  logic             flag_clr,
    input  logic             cmp_low,
    output logic             cmp_power,
    output logic [LVL_W-1:0] cmp_level,
    output logic             det_status,
    output logic             irq_flag,
    output logic             irq_req,
    output logic             rst_req
);

    logic smp_valid;
    logic det_evt;
    logic cont_mode;

    assign cont_mode = (cfg_mode == 2'd0);
    assign cmp_level = cfg_level;

    svm_seq #(
        .MASK_CYC (MASK_CYC),
        .INTV1    (INTV1),
        .INTV2    (INTV2),
        .INTV3    (INTV3)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (cfg_enable),
        .mode      (cfg_mode),
        .power     (cmp_power),
        .smp_valid (smp_valid)
    );

    svm_detect #(
        .MAX_SEL (3)
    ) u_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (cfg_enable),
        .cont      (cont_mode),
        .smp_valid (smp_valid),
        .cmp_low   (cmp_low),
        .cnt_sel   (cfg_count_sel),
        .status    (det_status),
        .evt       (det_evt)
    );

    svm_route u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt       (det_evt),
        .act_sel   (cfg_action_sel),
        .flag_clr  (flag_clr),
        .irq_en    (cfg_irq_en),
        .flag      (irq_flag),
        .irq       (irq_req),
        .rst_pulse (rst_req)
    );

endmodule

// File: rtl/svm_checker.sv
// Property checker for the supply monitor, bound to the top module.
// Assumes: bound into supply_monitor, where det_evt is the internal event.
module svm_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_enable,
    input logic [3:0] cfg_action_sel,
    input logic       flag_clr,
    input logic       det_evt,
    input logic       cmp_power,
    input logic       det_status,
    input logic       irq_flag,
    input logic       rst_req
);

    // R2
    pwr_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> !cmp_power);

    // R2
    status_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> !det_status);

    // R8
    rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R8
    rst_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> $past(cfg_action_sel) == 4'hA);

    // R9
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_flag && !flag_clr |=> irq_flag);

    // R9
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr && !det_evt |=> !irq_flag);

endmodule

bind supply_monitor svm_checker u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_enable     (cfg_enable),
    .cfg_action_sel (cfg_action_sel),
    .flag_clr       (flag_clr),
    .det_evt        (det_evt),
    .cmp_power      (cmp_power),
    .det_status     (det_status),
    .irq_flag       (irq_flag),
    .rst_req        (rst_req)
);

// File: tb/supply_monitor_test.sv
// Testbench: behavioural cycle model compared with the design on every clock.
module supply_monitor_test;

    localparam int PERIOD = 10;
    localparam int MASKC  = 16;
    localparam int LIMIT  = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_enable = 1'b0;
    logic [1:0] cfg_mode = 2'd0;
    logic [4:0] cfg_level = 5'd0;
    logic [1:0] cfg_count_sel = 2'd0;
    logic [3:0] cfg_action_sel = 4'd0;
    logic       cfg_irq_en = 1'b0;
    logic       flag_clr = 1'b0;
    logic       cmp_low = 1'b0;
    logic       cmp_power;
    logic [4:0] cmp_level;
    logic       det_status;
    logic       irq_flag;
    logic       irq_req;
    logic       rst_req;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit started = 0;
    bit done = 0;

    // Reference model state.
    bit m_on, m_status, m_evt, m_evt_d, m_flag, m_rst;
    int m_age, m_gap, m_run;

    supply_monitor uut (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_mode(cfg_mode),
        .cfg_level(cfg_level), .cfg_count_sel(cfg_count_sel),
        .cfg_action_sel(cfg_action_sel), .cfg_irq_en(cfg_irq_en),
        .flag_clr(flag_clr), .cmp_low(cmp_low), .cmp_power(cmp_power),
        .cmp_level(cmp_level), .det_status(det_status), .irq_flag(irq_flag),
        .irq_req(irq_req), .rst_req(rst_req)
    );

    always #(PERIOD/2) clk = ~clk;

    function automatic int interval_of(logic [1:0] md);
        if (md == 2'd1) return 256;
        if (md == 2'd2) return 1024;
        return 4096;
    endfunction

    // Model step on each rising edge, from inputs that are stable there.
    always @(posedge clk) begin
        bit key, valid, cont, n_rst, n_flag;
        int need;
        cycles++;
        if (!rst_n) begin
            m_on = 0; m_status = 0; m_evt = 0; m_evt_d = 0; m_flag = 0;
            m_rst = 0; m_age = 0; m_gap = 0; m_run = 0;
            started = 1;
        end else begin
            key    = (cfg_action_sel == 4'hA);
            cont   = (cfg_mode == 2'd0);
            need   = 1 << cfg_count_sel;
            n_rst  = m_evt && key && !m_evt_d;
            n_flag = (m_evt && !key) ? 1'b1 : (flag_clr ? 1'b0 : m_flag);
            m_evt_d = m_evt;
            valid  = m_on && (m_age >= MASKC);
            if (!cfg_enable) begin
                m_on = 0; m_age = 0; m_gap = 0; m_status = 0; m_run = 0; m_evt = 0;
            end else if (!m_on) begin
                m_evt = 0;
                if (m_gap == 0) begin m_on = 1; m_age = 0; end
                else m_gap--;
            end else if (valid) begin
                m_status = cmp_low;
                m_run = cmp_low ? ((m_run >= 8) ? 8 : m_run + 1) : 0;
                m_evt = cmp_low && (cont || m_run >= need);
                if (!cont) begin
                    m_on = 0;
                    m_gap = interval_of(cfg_mode) - MASKC - 2;
                end
            end else begin
                m_evt = 0;
                m_age++;
            end
            m_rst  = n_rst;
            m_flag = n_flag;
        end
    end

    task automatic check(string req, string what, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s %s at cycle %0d: actual %0d expected %0d",
                     req, what, cycles, act, exp);
        end
    endtask

    // Comparison shortly after each edge.
    always @(posedge clk) begin
        #2;
        if (started && !done) begin
            check("R1 R2 R3", "cmp_power", int'(cmp_power), int'(m_on));
            check("R3 R4 R5 R2", "det_status", int'(det_status), int'(m_status));
            check("R6 R7 R9", "irq_flag", int'(irq_flag), int'(m_flag));
            check("R8", "rst_req", int'(rst_req), int'(m_rst));
            check("R10", "irq_req", int'(irq_req), int'(m_flag && cfg_irq_en));
            check("R11", "cmp_level", int'(cmp_level), int'(cfg_level));
        end
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_pulse();
        @(negedge clk); flag_clr = 1'b1;
        @(negedge clk); flag_clr = 1'b0;
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        if (cycles > LIMIT && !done) begin
            mismatched++;
            $display("FAIL watchdog expired at cycle %0d: actual running expected finished", cycles);
            finish_run();
        end
    end

    initial begin
        // Reset state (R2).
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);

        // R11 and R4/R7: continuous mode, masking (R3) with the supply low early.
        cfg_level = 5'd19;
        cfg_enable = 1'b1;
        cmp_low = 1'b1;
        wait_cyc(10);              // inside the masking window (R3)
        cmp_low = 1'b0;
        wait_cyc(20);
        cmp_low = 1'b1;            // R7: event cycles set the flag
        wait_cyc(4);
        cfg_irq_en = 1'b1;         // R10
        clear_pulse();             // R9: set wins while still low
        cmp_low = 1'b0;
        wait_cyc(3);
        clear_pulse();             // R9: clear takes effect
        wait_cyc(3);
        cmp_low = 1'b1; wait_cyc(1); cmp_low = 1'b0; wait_cyc(4);
        cfg_irq_en = 1'b0;
        clear_pulse();
        cfg_level = 5'd7;
        cfg_enable = 1'b0;         // R2
        wait_cyc(5);

        // R8: reset key in continuous mode.
        cfg_action_sel = 4'hA;
        cfg_enable = 1'b1;
        wait_cyc(25);
        cmp_low = 1'b1; wait_cyc(8);
        cmp_low = 1'b0; wait_cyc(3);
        cmp_low = 1'b1; wait_cyc(2);
        cmp_low = 1'b0; wait_cyc(3);
        cfg_enable = 1'b0;
        wait_cyc(4);

        // R1 R5 R6: mode 1, run of four lows required.
        cfg_action_sel = 4'h3;
        cfg_mode = 2'd1;
        cfg_count_sel = 2'd2;
        cfg_irq_en = 1'b1;
        cfg_enable = 1'b1;
        cmp_low = 1'b1;
        wait_cyc(256 * 3);
        cmp_low = 1'b0;            // breaks the run
        wait_cyc(256);
        cmp_low = 1'b1;
        wait_cyc(256 * 6);
        clear_pulse();
        wait_cyc(256 * 2);
        cfg_enable = 1'b0;
        wait_cyc(5);
        clear_pulse();

        // R2: disable in the middle of a run clears it.
        cfg_count_sel = 2'd1;
        cfg_enable = 1'b1;
        wait_cyc(300);
        cfg_enable = 1'b0;
        wait_cyc(3);
        cfg_enable = 1'b1;
        wait_cyc(600);
        cfg_enable = 1'b0;
        wait_cyc(3);
        clear_pulse();

        // R1 R6 R8: mode 2, single low sample with the reset key.
        cfg_mode = 2'd2;
        cfg_count_sel = 2'd0;
        cfg_action_sel = 4'hA;
        cfg_enable = 1'b1;
        wait_cyc(1024 * 3);
        cmp_low = 1'b0;
        wait_cyc(1024);
        cfg_enable = 1'b0;
        wait_cyc(3);

        // R1 R6: mode 3, eight lows, with one good sample in the middle.
        cfg_mode = 2'd3;
        cfg_count_sel = 2'd3;
        cfg_action_sel = 4'h0;
        cfg_enable = 1'b1;
        cmp_low = 1'b1;
        wait_cyc(4096 * 5);
        cmp_low = 1'b0;
        wait_cyc(4096);
        cmp_low = 1'b1;
        wait_cyc(4096 * 9);
        cfg_enable = 1'b0;
        wait_cyc(5);

        finish_run();
    end

endmodule